// File: doc/BRIEF.md
# Per-Channel Trigger Condition Matcher

This block watches a sampled input bus, one bit per channel, and raises a trigger when every selected channel meets its own condition on the same valid sample. Each channel has three configuration bits, each held in its own word. The first bit chooses whether the channel is tested on its level or on a transition. The second bit chooses the sense: high or rising versus low or falling. The third bit says whether the channel takes part in the decision at all.

Software loads the three words through write-enable ports and then pulses `arm`. While armed, the block judges every sample that comes with `smp_vld`. The first sample that satisfies all enabled channels produces a one-cycle `trig_pulse` and sets the sticky `triggered` flag. After that the block stops judging samples until it is armed again. Transitions are found by comparing each valid sample with the valid sample before it in the same arming. Cycles without `smp_vld` are not samples.

Top module: `trig_match`

## Requirements
- R1: After reset, `trig_pulse`, `triggered` and `stat_o` are all zero. The block is not armed, and all three configuration words are zero.
- R2: A channel in level mode (mode bit 0) is satisfied when its sample bit equals its polarity bit: polarity 1 matches high and polarity 0 matches low.
- R3: A channel in edge mode (mode bit 1) is satisfied when its bit differs from the same bit of the previous valid sample and now equals its polarity bit: polarity 1 matches a rising edge and polarity 0 matches a falling edge. Cycles with `smp_vld` low neither count as samples nor replace the previous sample.
- R4: A channel whose enable bit is 0 has no effect on the decision. With an all-zero enable word, the first valid sample after arming triggers.
- R5: The trigger requires all enabled channels to be satisfied on the same valid sample (a logical AND).
- R6: The first valid sample after `arm` cannot satisfy an edge-mode channel.
- R7: `trig_pulse` is high for exactly the one cycle after the edge that takes the matching sample. It fires at most once per arming and never while the block is not armed. A sample presented in the same cycle as `arm` is not judged.
- R8: `triggered` rises together with `trig_pulse` and stays high until the next `arm`, which clears it. `stat_o[1]` is `triggered`, `stat_o[0]` is high while the block is armed and waiting, and all other status bits are 0.
- R9: A configuration write takes effect from the cycle after its write enable. A sample presented in the same cycle as a write is judged with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a new trigger search; clears the flag |
| smp_vld | input | 1 | Sample on `smp` is valid this cycle |
| smp | input | NCH | Sampled channel values |
| pol_we | input | 1 | Write enable for the polarity word |
| pol_wd | input | NCH | Polarity word (1 = high/rising) |
| mode_we | input | 1 | Write enable for the mode word |
| mode_wd | input | NCH | Mode word (1 = edge, 0 = level) |
| mask_we | input | 1 | Write enable for the enable word |
| mask_wd | input | NCH | Enable word (1 = channel takes part) |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered flag |
| stat_o | output | STW | Status: bit 1 triggered, bit 0 armed |

## Verification
A stale previous-sample register or a lost "have previous" bit causes edge channels to fire on the first sample after arming, or one sample late. This shows as a `trig_pulse` one cycle off its expected edge. An armed bit that fails to clear shows up as a second pulse within the same arming, on the next matching sample. A configuration register that updates too early or too late changes the verdict on a sample that coincides with the write, so the pulse appears or vanishes in that very cycle. The bench compares the pulse and the status word against a reference model on every cycle, so any of these faults is reported at the first cycle where the outputs differ from the model.

// File: rtl/trig_match.sv
module trig_match #(
  parameter int NCH = 32,
  parameter int STW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           smp_vld,
  input  logic [NCH-1:0] smp,
  input  logic           pol_we,
  input  logic [NCH-1:0] pol_wd,
  input  logic           mode_we,
  input  logic [NCH-1:0] mode_wd,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_wd,
  output logic           trig_pulse,
  output logic           triggered,
  output logic [STW-1:0] stat_o
);

  logic [NCH-1:0] pol_q, mode_q, mask_q, prev_q;
  logic armed_q, hp_q, trg_q, pulse_q;

  wire take = armed_q & smp_vld & ~arm;
  wire [NCH-1:0] lvl_ok = ~(smp ^ pol_q);
  wire [NCH-1:0] edg_ok = {NCH{hp_q}} & (smp ^ prev_q) & lvl_ok;
  wire [NCH-1:0] ch_ok  = (mode_q & edg_ok) | (~mode_q & lvl_ok);
  wire hit = &(ch_ok | ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      mode_q  <= '0;
      mask_q  <= '0;
      prev_q  <= '0;
      armed_q <= 1'b0;
      hp_q    <= 1'b0;
      trg_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (pol_we)  pol_q  <= pol_wd;
      if (mode_we) mode_q <= mode_wd;
      if (mask_we) mask_q <= mask_wd;
      pulse_q <= 1'b0;
      if (arm) begin
        armed_q <= 1'b1;
        hp_q    <= 1'b0;
        trg_q   <= 1'b0;
      end else if (take) begin
        prev_q <= smp;
        hp_q   <= 1'b1;
        if (hit) begin
          pulse_q <= 1'b1;
          trg_q   <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign trig_pulse = pulse_q;
  assign triggered  = trg_q;
  assign stat_o     = {{(STW-2){1'b0}}, trg_q, armed_q};

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse); // R7
  AST_PULSE_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(armed_q & smp_vld & ~arm)); // R7
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> triggered); // R8
  AST_ARM_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!triggered && stat_o[0])); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && !arm) |=> triggered); // R8
  AST_EMPTY_MASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mask_q == '0) |=> trig_pulse); // R4

endmodule

// File: tb/trig_match_tb.sv
module trig_match_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, smp_vld = 1'b0;
  logic [NCH-1:0] smp = '0;
  logic pol_we = 1'b0, mode_we = 1'b0, mask_we = 1'b0;
  logic [NCH-1:0] pol_wd = '0, mode_wd = '0, mask_wd = '0;
  logic trig_pulse, triggered;
  logic [31:0] stat_o;

  int total = 0, bad = 0;
  logic [NCH-1:0] m_pol = '0, m_mode = '0, m_mask = '0, m_prev = '0;
  logic m_arm = 1'b0, m_hp = 1'b0, m_trg = 1'b0, e_pulse = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_match #(.NCH(NCH), .STW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_vld(smp_vld), .smp(smp),
    .pol_we(pol_we), .pol_wd(pol_wd), .mode_we(mode_we), .mode_wd(mode_wd),
    .mask_we(mask_we), .mask_wd(mask_wd),
    .trig_pulse(trig_pulse), .triggered(triggered), .stat_o(stat_o));

  function automatic logic ref_hit(input logic [NCH-1:0] s);
    logic ok = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      logic c;
      if (m_mode[i]) c = m_hp && (s[i] != m_prev[i]) && (s[i] == m_pol[i]);
      else           c = (s[i] == m_pol[i]);
      if (m_mask[i] && !c) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    e_pulse = 1'b0;
    if (arm) begin
      m_arm = 1'b1; m_trg = 1'b0; m_hp = 1'b0;
    end else if (m_arm && smp_vld) begin
      if (ref_hit(smp)) begin
        e_pulse = 1'b1; m_trg = 1'b1; m_arm = 1'b0;
      end
      m_prev = smp; m_hp = 1'b1;
    end
    if (pol_we)  m_pol  = pol_wd;
    if (mode_we) m_mode = mode_wd;
    if (mask_we) m_mask = mask_wd;
    @(posedge clk); #1;
    check({tag, " pulse"}, {31'b0, trig_pulse}, {31'b0, e_pulse});
    check({tag, " status"}, stat_o, {30'b0, m_trg, m_arm});
    check({tag, " flag"}, {31'b0, triggered}, {31'b0, m_trg});
    arm = 0; smp_vld = 0; pol_we = 0; mode_we = 0; mask_we = 0;
  endtask

  task automatic cfg(input logic [NCH-1:0] p, input logic [NCH-1:0] m, input logic [NCH-1:0] k, input string tag);
    pol_we = 1; pol_wd = p; mode_we = 1; mode_wd = m; mask_we = 1; mask_wd = k;
    tick(tag);
  endtask

  task automatic sample(input logic [NCH-1:0] s, input string tag);
    smp_vld = 1; smp = s; tick(tag);
  endtask

  task automatic do_arm(input string tag);
    arm = 1; tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset status", stat_o, 32'h0);
    check("R1 reset pulse", {31'b0, trig_pulse}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", stat_o, 32'h0);
    sample(32'h0, "R1 zero mask unarmed no trigger R7");

    cfg(32'h1, 32'h0, 32'h1, "R2 cfg level high ch0");
    do_arm("R2 arm");
    sample(32'hFFFF_FFFE, "R2 low does not match high");
    sample(32'h1, "R2 high matches");
    sample(32'h1, "R7 no second pulse");
    cfg(32'h0, 32'h0, 32'h1, "R2 cfg level low ch0");
    do_arm("R2 arm");
    sample(32'h1, "R2 high does not match low");
    sample(32'h0, "R2 low matches");

    cfg(32'h8, 32'h8, 32'h8, "R3 cfg rising ch3");
    do_arm("R6 arm");
    sample(32'h8, "R6 first sample no edge");
    smp = 32'h0; tick("R3 invalid cycle ignored");
    sample(32'h8, "R3 no edge across invalid cycle");
    sample(32'h0, "R3 falling not rising");
    sample(32'h8, "R3 rising matches");
    cfg(32'h0, 32'h8, 32'h8, "R3 cfg falling ch3");
    do_arm("R3 arm");
    sample(32'h8, "R6 first sample");
    sample(32'h0, "R3 falling matches");

    cfg(32'h21, 32'h20, 32'h21, "R5 cfg ch0 high and ch5 rising");
    do_arm("R5 arm");
    sample(32'h0, "R5 none");
    sample(32'h20, "R5 edge only");
    sample(32'h1, "R5 level only");
    sample(32'h21, "R5 both");

    cfg(32'h0, 32'h0, 32'h0, "R4 empty mask");
    do_arm("R4 arm");
    sample(32'hDEAD_BEEF, "R4 empty mask fires first sample");
    cfg(32'h1, 32'hFFFF_FFFE, 32'h1, "R4 others masked");
    do_arm("R4 arm");
    sample(32'hFFFF_FFF0, "R4 masked toggles ignored");
    sample(32'h0000_000F, "R4 enabled match fires");
    repeat (3) sample(32'h1, "R8 flag sticky");
    do_arm("R8 arm clears flag");

    cfg(32'h0, 32'h0, 32'h1, "R9 cfg level low");
    do_arm("R9 arm");
    smp_vld = 1; smp = 32'h1; pol_we = 1; pol_wd = 32'h1;
    tick("R9 write same cycle uses old");
    sample(32'h1, "R9 new polarity applies");
    do_arm("R7 arm with sample");
    arm = 1; smp_vld = 1; smp = 32'h1; tick("R7 sample with arm not judged");
    sample(32'h1, "R7 judged after arm");

    begin
      logic [NCH-1:0] cur = '0;
      for (int n = 0; n < 4000; n++) begin
        int op = $urandom_range(0, 99);
        if (op < 3) arm = 1;
        if (op >= 3 && op < 6) begin
          mask_we = 1; mask_wd = $urandom & $urandom & $urandom;
          mode_we = 1; mode_wd = $urandom;
          pol_we = 1; pol_wd = $urandom;
        end
        cur = cur ^ ($urandom & $urandom & $urandom);
        smp = cur;
        smp_vld = ($urandom_range(0, 3) != 0);
        tick("R5 random R2 R3 R4 R8");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule